// File: doc/BRIEF.md
# Integer Data-Processing ALU with Condition Flags

A purely combinational 32-bit arithmetic/logic unit for the execute stage of a load/store processor core. A 4-bit opcode selects one of sixteen operations. These include bitwise logic, add and subtract with and without carry, reverse subtract, compare and test, move, and move-inverted. The unit works on a first operand and a second operand that an upstream shifter has already processed. It returns the 32-bit result, a write-enable for the destination register, and the next value of the four condition flags.

Each opcode belongs to one of four flag classes:

- **Add-type:** carry and overflow come from `op1 + op2 + cin`.
- **Subtract-type:** carry and overflow come from `op1 + ~op2 + cin`.
- **Reverse-subtract-type:** carry and overflow come from `op2 + ~op1 + cin`.
- **Logical:** carry comes from the shifter's carry-out, and overflow is left as it was.

So after a subtract, a carry of 1 means that no borrow occurred. Compare and test opcodes only update flags. New flags appear only when the set-flags input is high.

Top module: `dp_alu`

## Requirements
- R1: Logical results: 0x0 gives a&b, 0x1 gives a^b, 0xC gives a|b, 0xD gives b, 0xE gives a&~b, and 0xF gives ~b. The test opcodes 0x8 and 0x9 produce a&b and a^b on `result`.
- R2: Arithmetic results, where C is `flags_in[1]`: 0x4 gives a+b, 0x5 gives a+b+C, 0x2 gives a-b, 0x6 gives a-b-!C, 0x3 gives b-a, and 0x7 gives b-a-!C. The compare opcodes 0xA and 0xB produce a-b and a+b on `result`. All values wrap modulo 2^32.
- R3: `result_we` is 0 for opcodes 0x8, 0x9, 0xA and 0xB, and 1 for every other opcode.
- R4: Add-class opcodes 0x4, 0x5 and 0xB take C as bit 32 of `a+b+cin`. They set V when a and b have the same sign and the result's sign differs from it. cin is 0, except for 0x5, where it is the incoming C.
- R5: Subtract-class opcodes 0x2, 0x6 and 0xA take C and V from `a+~b+cin`, so C=1 means no borrow. cin is 1, except for 0x6, where it is the incoming C.
- R6: Reverse-subtract opcodes 0x3 and 0x7 take C and V from `b+~a+cin`. cin is 1, except for 0x7, where it is the incoming C.
- R7: Logical-class opcodes (0x0, 0x1, 0x8, 0x9, 0xC, 0xD, 0xE, 0xF) set C equal to `shift_cout` and keep V equal to `flags_in[0]`.
- R8: When `set_flags` is 1, N equals bit 31 of the computed value and Z is 1 exactly when that value is zero. This also holds for the compare and test opcodes.
- R9: When `set_flags` is 0, `flags_out` equals `flags_in`. The flag bit order is {N,Z,C,V} from bit 3 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 4 | Operation select |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand, already shifted |
| shift_cout | input | 1 | Carry-out of the operand shifter |
| set_flags | input | 1 | Update flags when 1 |
| flags_in | input | 4 | Current {N,Z,C,V} |
| result | output | 32 | Computed value |
| result_we | output | 1 | Destination write-enable |
| flags_out | output | 4 | Next {N,Z,C,V} |

## Verification
The hardest cases to reach are where the three carry-in sources meet the wrap-around boundaries:

- a subtract-with-carry whose not-borrow input flips the carry-out;
- a reverse subtract, whose operand swap must show up in both carry and overflow;
- overflow at the most negative value.

The vector table puts specific operands at these boundaries. Examples are 0x80000000 minus 1, 0x7FFFFFFF plus 1, and all-ones plus a carry-in. A pseudo-random sweep over all sixteen opcodes is then compared against a model that works in 64-bit signed and unsigned arithmetic rather than inverted-operand sums.

// File: rtl/dp_alu.sv
module dp_alu #(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op_code,
  input  logic [WIDTH-1:0] src_a,
  input  logic [WIDTH-1:0] src_b,
  input  logic             shift_cout,
  input  logic             set_flags,
  input  logic [3:0]       flags_in,
  output logic [WIDTH-1:0] result,
  output logic             result_we,
  output logic [3:0]       flags_out
);
  localparam int MSB = WIDTH - 1;

  typedef enum logic [1:0] {CLS_LOGIC, CLS_ADD, CLS_SUB, CLS_RSB} flag_cls_e;

  flag_cls_e        cls;
  logic             carry_in;
  logic [WIDTH-1:0] add_x, add_y, logic_res;
  logic [WIDTH:0]   sum;
  logic             c_new, v_new;

  always_comb begin
    case (op_code)
      4'h2, 4'h6, 4'hA: cls = CLS_SUB;
      4'h3, 4'h7:       cls = CLS_RSB;
      4'h4, 4'h5, 4'hB: cls = CLS_ADD;
      default:          cls = CLS_LOGIC;
    endcase
  end

  always_comb begin
    case (op_code)
      4'h2, 4'h3, 4'hA: carry_in = 1'b1;
      4'h5, 4'h6, 4'h7: carry_in = flags_in[1];
      default:          carry_in = 1'b0;
    endcase
  end

  assign add_x = (cls == CLS_RSB) ? src_b : src_a;
  assign add_y = (cls == CLS_SUB) ? ~src_b :
                 (cls == CLS_RSB) ? ~src_a : src_b;
  assign sum   = {1'b0, add_x} + {1'b0, add_y} + {{WIDTH{1'b0}}, carry_in};

  always_comb begin
    case (op_code)
      4'h0, 4'h8: logic_res = src_a & src_b;
      4'h1, 4'h9: logic_res = src_a ^ src_b;
      4'hC:       logic_res = src_a | src_b;
      4'hD:       logic_res = src_b;
      4'hE:       logic_res = src_a & ~src_b;
      default:    logic_res = ~src_b;
    endcase
  end

  assign result    = (cls == CLS_LOGIC) ? logic_res : sum[MSB:0];
  assign result_we = (op_code[3:2] != 2'b10);

  assign c_new = (cls == CLS_LOGIC) ? shift_cout : sum[WIDTH];
  assign v_new = (cls == CLS_LOGIC) ? flags_in[0] :
                 ((add_x[MSB] == add_y[MSB]) && (sum[MSB] != add_x[MSB]));

  assign flags_out = set_flags ? {result[MSB], (result == '0), c_new, v_new} : flags_in;

  always_comb begin
    // R9
    hold_chk: assert (set_flags || flags_out == flags_in);
    // R8
    neg_chk: assert (!set_flags || flags_out[3] == result[MSB]);
    // R8
    zero_chk: assert (!set_flags || flags_out[2] == (result == '0));
    // R7
    logic_cv_chk: assert (!set_flags || cls != CLS_LOGIC ||
                          (flags_out[1] == shift_cout && flags_out[0] == flags_in[0]));
    // R3
    cmp_we_chk: assert (!(op_code inside {4'h8, 4'h9, 4'hA, 4'hB}) || !result_we);
    // R5
    sub_val_chk: assert (op_code != 4'h2 || result == src_a - src_b);
    // R6
    rsb_val_chk: assert (op_code != 4'h3 || result == src_b - src_a);
    // R4
    add_carry_chk: assert (!set_flags || op_code != 4'h4 || flags_out[1] == (result < src_a));
  end
endmodule

// File: tb/test_dp_alu.sv
module test_dp_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_code;
  logic [31:0] src_a, src_b;
  logic        shift_cout, set_flags;
  logic [3:0]  flags_in;
  logic [31:0] result;
  logic        result_we;
  logic [3:0]  flags_out;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dp_alu i_dp_alu (
    .op_code(op_code), .src_a(src_a), .src_b(src_b), .shift_cout(shift_cout),
    .set_flags(set_flags), .flags_in(flags_in), .result(result),
    .result_we(result_we), .flags_out(flags_out)
  );

  // {op, a, b, shift_cout, flags_in, set_flags, exp_result, exp_we, exp_flags}
  localparam int NV = 21;
  localparam logic [110:0] VEC [NV] = '{
    {4'h4, 32'h7FFFFFFF, 32'h00000001, 1'b0, 4'h0, 1'b1, 32'h80000000, 1'b1, 4'b1001},
    {4'h4, 32'hFFFFFFFF, 32'h00000001, 1'b0, 4'h0, 1'b1, 32'h00000000, 1'b1, 4'b0110},
    {4'h2, 32'h00000005, 32'h00000005, 1'b0, 4'h0, 1'b1, 32'h00000000, 1'b1, 4'b0110},
    {4'h2, 32'h00000003, 32'h00000005, 1'b0, 4'h0, 1'b1, 32'hFFFFFFFE, 1'b1, 4'b1000},
    {4'h2, 32'h80000000, 32'h00000001, 1'b0, 4'h0, 1'b1, 32'h7FFFFFFF, 1'b1, 4'b0011},
    {4'h3, 32'h00000001, 32'h00000000, 1'b0, 4'h0, 1'b1, 32'hFFFFFFFF, 1'b1, 4'b1000},
    {4'h5, 32'h00000001, 32'h00000002, 1'b0, 4'h2, 1'b1, 32'h00000004, 1'b1, 4'b0000},
    {4'h6, 32'h0000000A, 32'h00000003, 1'b0, 4'h0, 1'b1, 32'h00000006, 1'b1, 4'b0010},
    {4'h7, 32'h00000003, 32'h0000000A, 1'b0, 4'h2, 1'b1, 32'h00000007, 1'b1, 4'b0010},
    {4'hA, 32'h00000007, 32'h00000007, 1'b0, 4'h9, 1'b1, 32'h00000000, 1'b0, 4'b0110},
    {4'hB, 32'hFFFFFFFF, 32'h00000001, 1'b0, 4'h0, 1'b1, 32'h00000000, 1'b0, 4'b0110},
    {4'h8, 32'h000000F0, 32'h0000000F, 1'b1, 4'h1, 1'b1, 32'h00000000, 1'b0, 4'b0111},
    {4'h9, 32'h80000000, 32'h00000000, 1'b0, 4'h3, 1'b1, 32'h80000000, 1'b0, 4'b1001},
    {4'h0, 32'hFF00FF00, 32'h0FF00FF0, 1'b0, 4'h0, 1'b1, 32'h0F000F00, 1'b1, 4'b0000},
    {4'h1, 32'hFFFF0000, 32'h00FFFF00, 1'b1, 4'h0, 1'b1, 32'hFF00FF00, 1'b1, 4'b1010},
    {4'hC, 32'h00000001, 32'h80000000, 1'b0, 4'h1, 1'b1, 32'h80000001, 1'b1, 4'b1001},
    {4'hD, 32'h12345678, 32'h00000000, 1'b1, 4'h0, 1'b1, 32'h00000000, 1'b1, 4'b0110},
    {4'hE, 32'hFFFFFFFF, 32'h0000FFFF, 1'b0, 4'h0, 1'b1, 32'hFFFF0000, 1'b1, 4'b1000},
    {4'hF, 32'h00000000, 32'hFFFFFFFF, 1'b0, 4'h1, 1'b1, 32'h00000000, 1'b1, 4'b0101},
    {4'h4, 32'h7FFFFFFF, 32'h00000001, 1'b0, 4'h5, 1'b0, 32'h80000000, 1'b1, 4'b0101},
    {4'hA, 32'h00000001, 32'h00000001, 1'b1, 4'hF, 1'b0, 32'h00000000, 1'b0, 4'b1111}
  };

  function automatic string res_tag(logic [3:0] op);
    return (op inside {4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'hA, 4'hB}) ? "R2" : "R1";
  endfunction

  function automatic string flag_tag(logic [3:0] op, logic sf);
    if (!sf) return "R9";
    if (op inside {4'h4, 4'h5, 4'hB}) return "R4";
    if (op inside {4'h2, 4'h6, 4'hA}) return "R5";
    if (op inside {4'h3, 4'h7}) return "R6";
    return "R7";
  endfunction

  // Returns {we, flags, result}; uses 64-bit signed/unsigned arithmetic.
  function automatic logic [36:0] model(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                                        logic sc, logic [3:0] fi, logic sf);
    longint ua = longint'({32'b0, a});
    longint ub = longint'({32'b0, b});
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint c  = longint'(fi[1]);
    longint u = 0, s = 0;
    logic [31:0] r;
    logic cf = sc, vf = fi[0], arith = 1'b1, subu = 1'b0;
    case (op)
      4'h4, 4'hB: begin u = ua + ub;         s = sa + sb; end
      4'h5:       begin u = ua + ub + c;     s = sa + sb + c; end
      4'h2, 4'hA: begin u = ua - ub;         s = sa - sb;         subu = 1'b1; end
      4'h6:       begin u = ua - ub - 1 + c; s = sa - sb - 1 + c; subu = 1'b1; end
      4'h3:       begin u = ub - ua;         s = sb - sa;         subu = 1'b1; end
      4'h7:       begin u = ub - ua - 1 + c; s = sb - sa - 1 + c; subu = 1'b1; end
      default: arith = 1'b0;
    endcase
    if (arith) begin
      r  = u[31:0];
      cf = subu ? (u >= 0) : (u > 64'sh00000000FFFFFFFF);
      vf = (s > 64'sh000000007FFFFFFF) || (s < -64'sh0000000080000000);
    end else begin
      case (op)
        4'h0, 4'h8: r = a & b;
        4'h1, 4'h9: r = a ^ b;
        4'hC:       r = a | b;
        4'hD:       r = b;
        4'hE:       r = a & ~b;
        default:    r = ~b;
      endcase
    end
    return {!(op inside {4'h8, 4'h9, 4'hA, 4'hB}),
            sf ? {r[31], r == 32'h0, cf, vf} : fi, r};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s op=%h actual=%h expected=%h", req, what, op_code, act, exp);
    end
  endtask

  task automatic apply(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                       logic sc, logic [3:0] fi, logic sf);
    @(posedge clk);
    #1;
    op_code = op; src_a = a; src_b = b; shift_cout = sc; flags_in = fi; set_flags = sf;
    @(negedge clk);
  endtask

  task automatic chk_model(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                           logic sc, logic [3:0] fi, logic sf);
    logic [36:0] m;
    apply(op, a, b, sc, fi, sf);
    m = model(op, a, b, sc, fi, sf);
    chk(res_tag(op), "result", result, m[31:0]);
    chk("R3", "we", {31'b0, result_we}, {31'b0, m[36]});
    chk(flag_tag(op, sf), "flags", {28'b0, flags_out}, {28'b0, m[35:32]});
    if (sf) chk("R8", "nz", {30'b0, flags_out[3:2]}, {30'b0, m[35:34]});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lfsr = 32'hACE1_2024;
    op_code = 4'h0; src_a = '0; src_b = '0; shift_cout = 1'b0; flags_in = 4'h0; set_flags = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state, all-zero inputs: AND of zeros, flags held (R1, R9)
    chk("R1", "reset result", result, 32'h0);
    chk("R9", "reset flags", {28'b0, flags_out}, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [110:0] v = VEC[i];
      apply(v[110:107], v[106:75], v[74:43], v[42], v[41:38], v[37]);
      chk(res_tag(v[110:107]), "result", result, v[36:5]);
      chk("R3", "we", {31'b0, result_we}, {31'b0, v[4]});
      chk(flag_tag(v[110:107], v[37]), "flags", {28'b0, flags_out}, {28'b0, v[3:0]});
    end

    // R4: most negative plus itself wraps to zero with carry and overflow
    apply(4'h4, 32'h80000000, 32'h80000000, 1'b0, 4'h0, 1'b1);
    chk("R4", "min+min flags", {28'b0, flags_out}, 32'b0111);
    // R4: carry-in pushes all-ones over the top
    apply(4'h5, 32'hFFFFFFFF, 32'h0, 1'b0, 4'h2, 1'b1);
    chk("R4", "adc wrap", {28'b0, flags_out}, 32'b0110);
    // R5: SBC with no incoming carry borrows once more: 0 - 0 - 1
    apply(4'h6, 32'h0, 32'h0, 1'b0, 4'h0, 1'b1);
    chk("R5", "sbc borrow result", result, 32'hFFFFFFFF);
    chk("R5", "sbc borrow flags", {28'b0, flags_out}, 32'b1000);
    // R6: reverse subtract overflow: 0x7FFFFFFF - (-1)
    apply(4'h3, 32'hFFFFFFFF, 32'h7FFFFFFF, 1'b0, 4'h0, 1'b1);
    chk("R6", "rsb overflow", {28'b0, flags_out}, 32'b1001);
    // R7: logical op keeps V set and takes carry from shifter
    apply(4'hD, 32'h0, 32'h00000001, 1'b1, 4'b0001, 1'b1);
    chk("R7", "mov carry", {28'b0, flags_out}, 32'b0011);

    for (int i = 0; i < 64; i++) begin
      logic [31:0] a, b;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      b = (i % 5 == 0) ? a : lfsr;
      chk_model(4'(i), a, b, lfsr[3], lfsr[7:4], (i % 7) != 3);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule